// File: doc/BRIEF.md
# Paddle Sample Window Timer

This block times the conversion window that turns two paddle resistances into digital readings. It watches the three lowest bits of the vertical line counter. When all three are zero, on lines 0, 8, 16 and so on, it raises a group-line strobe for that whole scan line. While the strobe is high, both paddle pins are pulled low to discharge their timing capacitors, and the shared sample counter is held at zero. On the other seven lines of the group, the counter climbs once per clock cycle. It stops at 255 and does not wrap. The comparators elsewhere latch the count when their pin crosses threshold, and both channels read the same counter.

The two-phase clock is modelled as one fast system clock with two enable strobes, ph1_en and ph2_en. The increment decision is taken on a phase-1 enable and used up on the next phase-2 enable. A scan line is 71 phase pairs in PAL timing and 65 in NTSC timing, so the whole cycle repeats every 568 or 520 phase pairs. The logic itself depends only on the line bits. The standard only sets how long the line generator outside the block holds each value.

Top module: `paddle_window_timer`

## Requirements
- R1: `line8_strobe` is 1 exactly when the three `vline_lo` bits are all zero. It follows the input within the same cycle.
- R2: Every bit of `pad_discharge` (bit 0 is the X pin, bit 1 is the Y pin) equals `line8_strobe` in the same cycle.
- R3: On any clock edge where `line8_strobe` is high, `count` becomes 0. It stays at 0 for every cycle of the group line.
- R4: Outside a group line, `count` rises by exactly one on a `ph2_en` edge. This happens only if the last `ph1_en` edge before it found the strobe low and the count below 255. `count` never changes on a `ph1_en` edge or on an idle edge.
- R5: `at_max` is 1 exactly when `count` is 255. Once `count` reaches 255 it stays there until the next group line or reset; it never wraps to 0.
- R6: If the strobe is high on a `ph2_en` edge whose decision was armed, the hold to zero wins and the count becomes 0.
- R7: When `rst` is high at a clock edge, `count` becomes 0 and any armed increment decision is cleared.
- R8: A decision armed by one `ph1_en` is used up by the next `ph2_en`. A second `ph2_en` with no `ph1_en` between them leaves `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ph1_en | input | 1 | Phase-1 enable strobe |
| ph2_en | input | 1 | Phase-2 enable strobe |
| vline_lo | input | 3 | Low bits of the vertical line counter |
| count | output | 8 | Shared paddle sample count |
| at_max | output | 1 | Count is at 255 |
| line8_strobe | output | 1 | Group-line (every eighth line) strobe |
| pad_discharge | output | 2 | Pull-down enables, bit 0 X pin, bit 1 Y pin |

## Verification
Hold-to-zero and increment can fall on the same edge. This happens when the line bits turn to zero between an armed phase-1 edge and the phase-2 edge that would use the decision. The bench provokes this directly: it arms the counter on line 7 and moves the line bits to zero just before the phase-2 edge. The count is then judged to read 0, not the old value plus one. Saturation and the start of the next group line also meet, at the end of long PAL and NTSC runs where the count has sat at 255 for many cycles.

// File: rtl/paddle_pkg.sv
package paddle_pkg;
  localparam int CNT_W    = 8;
  localparam int VSEL_W   = 3;
  localparam int NUM_PADS = 2;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur);
    return cur + CNT_W'(1);
  endfunction

  function automatic logic group_line(input logic [VSEL_W-1:0] v);
    return (v == '0);
  endfunction
endpackage

// File: rtl/line_group_decode.sv
module line_group_decode
  import paddle_pkg::*;
#(
  parameter int VW = VSEL_W
) (
  input  logic [VW-1:0] vline_lo,
  output logic          group_hit
);
  always_comb group_hit = (vline_lo == '0);
endmodule

// File: rtl/sample_counter.sv
module sample_counter
  import paddle_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph1_en,
  input  logic          ph2_en,
  input  logic          hold_zero,
  output logic [CW-1:0] count,
  output logic          at_max,
  output logic          inc_fire
);
  logic armed;

  always_comb at_max   = &count;
  always_comb inc_fire = ph2_en && armed && !hold_zero;

  // Decision taken on phase 1, used up on phase 2
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (ph1_en) begin
      armed <= !hold_zero && !at_max;
    end else if (ph2_en) begin
      armed <= 1'b0;
    end
  end

  // Hold to zero has priority over the increment
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (hold_zero) begin
      count <= '0;
    end else if (inc_fire) begin
      count <= count + CW'(1);
    end
  end
endmodule

// File: rtl/discharge_drive.sv
module discharge_drive #(
  parameter int NP = 2
) (
  input  logic          group_hit,
  output logic [NP-1:0] pull_low
);
  for (genvar g = 0; g < NP; g++) begin : g_pad
    assign pull_low[g] = group_hit;
  end
endmodule

// File: rtl/paddle_window_timer.sv
module paddle_window_timer
  import paddle_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int VW = VSEL_W,
  parameter int NP = NUM_PADS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ph1_en,
  input  logic          ph2_en,
  input  logic [VW-1:0] vline_lo,
  output logic [CW-1:0] count,
  output logic          at_max,
  output logic          line8_strobe,
  output logic [NP-1:0] pad_discharge
);
  logic group_hit;
  logic inc_fire;

  line_group_decode #(.VW(VW)) i_decode (
    .vline_lo (vline_lo),
    .group_hit(group_hit)
  );

  sample_counter #(.CW(CW)) i_counter (
    .clk      (clk),
    .rst      (rst),
    .ph1_en   (ph1_en),
    .ph2_en   (ph2_en),
    .hold_zero(group_hit),
    .count    (count),
    .at_max   (at_max),
    .inc_fire (inc_fire)
  );

  discharge_drive #(.NP(NP)) i_discharge (
    .group_hit(group_hit),
    .pull_low (pad_discharge)
  );

  assign line8_strobe = group_hit;
endmodule

// File: rtl/paddle_window_checker.sv
module paddle_window_checker #(
  parameter int CW = 8,
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          ph2_en,
  input logic          line8_strobe,
  input logic [NP-1:0] pad_discharge,
  input logic [CW-1:0] count,
  input logic          at_max,
  input logic          inc_fire
);
  // R2
  a_r2_pads_follow: assert property (@(posedge clk) disable iff (rst)
    pad_discharge == {NP{line8_strobe}});

  // R3, R6
  a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
    line8_strobe |=> (count == '0));

  // R4
  a_r4_only_ph2: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count) && count != '0) |-> $past(ph2_en));

  // R4
  a_r4_step_one: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count) && count != '0) |-> (count == CW'($past(count) + 1'b1)));

  // R5
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (at_max && !line8_strobe) |=> at_max);

  // R4: a fired increment is visible on the next edge
  a_r4_fire_seen: assert property (@(posedge clk) disable iff (rst)
    inc_fire |=> (count != '0));
endmodule

bind paddle_window_timer paddle_window_checker #(.CW(CW), .NP(NP)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .ph2_en       (ph2_en),
  .line8_strobe (line8_strobe),
  .pad_discharge(pad_discharge),
  .count        (count),
  .at_max       (at_max),
  .inc_fire     (inc_fire)
);

// File: tb/test_paddle_window_timer.sv
`timescale 1ns/1ps
module test_paddle_window_timer;
  localparam int CW = 8;
  localparam int VW = 3;
  localparam int NP = 2;

  typedef struct {
    int    cnt;
    bit    grp;
    string tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ph1_en = 1'b0;
  logic          ph2_en = 1'b0;
  logic [VW-1:0] vline_lo = '0;
  logic [CW-1:0] count;
  logic          at_max;
  logic          line8_strobe;
  logic [NP-1:0] pad_discharge;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  // Bench reference state
  int m_cnt = 0;
  bit m_arm = 0;

  always #2.5 clk = ~clk;

  paddle_window_timer i_paddle_window_timer (
    .clk(clk), .rst(rst), .ph1_en(ph1_en), .ph2_en(ph2_en),
    .vline_lo(vline_lo), .count(count), .at_max(at_max),
    .line8_strobe(line8_strobe), .pad_discharge(pad_discharge)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply inputs for the next edge and queue the predicted result
  task automatic tick(input bit r, input bit p1, input bit p2, input int line);
    bit    grp;
    int    nc;
    bit    na;
    string tg;
    @(negedge clk);
    rst = r; ph1_en = p1; ph2_en = p2; vline_lo = VW'(line);
    grp = (line % 8) == 0;
    nc = m_cnt; na = m_arm; tg = "R4";
    if (r) begin
      nc = 0; na = 0; tg = "R7";
    end else begin
      if (p1)      na = !grp && (m_cnt < 255);
      else if (p2) na = 0;
      if (grp) begin
        nc = 0;
        tg = (p2 && m_arm) ? "R6" : "R3";
      end else if (p2 && m_arm) begin
        nc = (m_cnt < 255) ? m_cnt + 1 : m_cnt;
      end else if (p2 && !m_arm && !p1) begin
        tg = (m_cnt == 255) ? "R5" : "R8";
      end else if (m_cnt == 255) begin
        tg = "R5";
      end
    end
    m_cnt = nc; m_arm = na;
    q.push_back('{cnt: nc, grp: grp, tag: tg});
  endtask

  // Monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(count == CW'(e.cnt), e.tag, int'(count), e.cnt);
        check(line8_strobe == e.grp, "R1", int'(line8_strobe), int'(e.grp));
        check(pad_discharge == {NP{e.grp}}, "R2", int'(pad_discharge), e.grp ? 3 : 0);
        check(at_max == (e.cnt == 255), "R5", int'(at_max), int'(e.cnt == 255));
      end
    end
  end

  task automatic run_std(input int line_len, input int first_line, input int groups);
    for (int ln = first_line; ln < first_line + groups * 8; ln++) begin
      for (int c = 0; c < line_len; c++) begin
        tick(0, 1, 0, ln);
        tick(0, 0, 1, ln);
      end
    end
  endtask

  initial begin
    tick(1, 0, 0, 3);
    tick(1, 1, 0, 3);  // R7 reset state with a phase-1 pending
    tick(0, 0, 1, 3);  // R7 cleared decision: no increment
    // R8: two phase-2 edges after one phase-1
    tick(0, 1, 0, 1);
    tick(0, 0, 1, 1);
    tick(0, 0, 1, 1);
    tick(0, 0, 0, 1);
    // R6: armed on line 7, group line arrives before phase 2
    tick(0, 1, 0, 7);
    tick(0, 0, 1, 7);
    tick(0, 1, 0, 7);
    tick(0, 0, 1, 0);
    // R4: phase 1 alone never moves the count
    tick(0, 1, 0, 2);
    tick(0, 1, 0, 2);
    tick(0, 0, 1, 2);
    // PAL: 71 cycles per line, R5 saturation reached
    run_std(71, 0, 2);
    // NTSC: 65 cycles per line, starting mid-group
    run_std(65, 13, 2);
    // R7: reset in mid line
    tick(0, 1, 0, 4);
    tick(1, 0, 1, 4);
    tick(0, 1, 0, 4);
    tick(0, 0, 1, 4);
    run_std(65, 0, 1);
    @(posedge clk);
    #2;
    done = 1;
  end

  initial begin
    for (int n = 0; n < 200000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule